// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterized register (eight stages by default) that can keep its contents, move them one stage toward the high end, move them one stage toward the low end, or take a full word from the parallel bus. Every change happens on the rising clock edge. The only exception is the active-low master clear, which empties every stage at once, whatever the clock and the mode select are doing.

Inside a chip the shared parallel bus is split into three signals: an input word, an output word and a single drive-enable. A tri-state wrapper or a bench can resolve the real bus from them. The driver is enabled only when both active-low enables are low. It is also switched off whenever the block is sampling the bus for a load.

The lowest and highest stages each have their own serial output, which the bus enables do not gate. Several blocks can be chained through them: one block's high-end output feeds the next block's low-end serial input.

Top module: `usr_shift_reg`

## Requirements
- R1: With `sel` = 2'b11, a rising clock edge copies `par_in[n]` into stage n for every n.
- R2: With `sel` = 2'b01, a rising clock edge puts `ser_up_in` into stage 0 and moves stage k-1 into stage k for k from 1 to the top.
- R3: With `sel` = 2'b10, a rising clock edge puts `ser_dn_in` into the top stage and moves stage k+1 into stage k for k from 0 to the next-to-top.
- R4: With `sel` = 2'b00, the contents stay unchanged across clock edges, and changes on `par_in`, `ser_up_in` and `ser_dn_in` have no effect.
- R5: While `mr_n` is low, every stage reads 0. The clear takes effect without waiting for a clock edge, and clock edges during the clear do not load, shift or otherwise change the contents.
- R6: `par_oe` is 1 only when `bus_en_a_n` and `bus_en_b_n` are both 0 and `sel` is not 2'b11; otherwise it is 0.
- R7: `par_out[n]` always shows stage n. Stage 0 is the least significant bit.
- R8: `tail_lo` shows stage 0 and `tail_hi` shows the top stage, whatever the bus enables are.
- R9: The first rising edge after `mr_n` returns high carries out the selected mode, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register acts on the rising edge |
| mr_n | input | 1 | Asynchronous master clear, active low |
| sel | input | 2 | Mode: 00 keep, 01 move up, 10 move down, 11 load |
| ser_up_in | input | 1 | Serial bit entering stage 0 when moving up |
| ser_dn_in | input | 1 | Serial bit entering the top stage when moving down |
| bus_en_a_n | input | 1 | First bus drive enable, active low |
| bus_en_b_n | input | 1 | Second bus drive enable, active low |
| par_in | input | WIDTH | Parallel bus value as seen by the block |
| par_out | output | WIDTH | Register contents presented to the bus driver |
| par_oe | output | 1 | Bus drive enable for the tri-state wrapper |
| tail_lo | output | 1 | Serial output from stage 0 |
| tail_hi | output | 1 | Serial output from the top stage |

## Verification
Two functions can fall in the same cycle: a load, and a bus drive request with both enables low. The bench sets up this collision by selecting the load mode while it holds both enables asserted. It then checks two things: that `par_oe` reads 0 before the edge, and that the loaded word appears on `par_out` after the edge. A second collision is a master clear that is low while the load mode and a clock edge are present. The bench judges it by the contents staying zero. It then checks that the first edge after release loads at once.

// File: rtl/usr_pkg.sv
package usr_pkg;

    localparam int USR_WIDTH = 8;

    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

    typedef struct packed {
        logic up_in;
        logic dn_in;
    } usr_serial_t;

    function automatic logic usr_may_drive(usr_mode_e m, logic en_a_n, logic en_b_n);
        return (m != MODE_LOAD) && !en_a_n && !en_b_n;
    endfunction

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] sel,
    output usr_mode_e  mode
);
    always_comb begin
        unique case (sel)
            2'b00:   mode = MODE_KEEP;
            2'b01:   mode = MODE_UP;
            2'b10:   mode = MODE_DOWN;
            default: mode = MODE_LOAD;
        endcase
    end
endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array
    import usr_pkg::*;
#(
    parameter int WIDTH = USR_WIDTH
) (
    input  logic             clk,
    input  logic             mr_n,
    input  usr_mode_e        mode,
    input  usr_serial_t      ser,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] nxt;

    // Each stage chooses its next value from its own inputs and its two neighbours.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_lo
            assign from_below = ser.up_in;
        end else begin : g_lo_mid
            assign from_below = q[i-1];
        end

        if (i == TOP) begin : g_hi
            assign from_above = ser.dn_in;
        end else begin : g_hi_mid
            assign from_above = q[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_UP:   nxt[i] = from_below;
                MODE_DOWN: nxt[i] = from_above;
                MODE_LOAD: nxt[i] = par_in[i];
                default:   nxt[i] = q[i];
            endcase
        end

        always_ff @(posedge clk or negedge mr_n) begin
            if (!mr_n) q[i] <= 1'b0;
            else       q[i] <= nxt[i];
        end
    end

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!mr_n)
        mode == MODE_LOAD |=> q == $past(par_in)); // R1

    AST_UP_MOVES: assert property (@(posedge clk) disable iff (!mr_n)
        mode == MODE_UP |=> q == {$past(q[TOP-1:0]), $past(ser.up_in)}); // R2

    AST_DOWN_MOVES: assert property (@(posedge clk) disable iff (!mr_n)
        mode == MODE_DOWN |=> q == {$past(ser.dn_in), $past(q[TOP:1])}); // R3

    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!mr_n)
        mode == MODE_KEEP |=> $stable(q)); // R4

    AST_CLEAR_EMPTY: assert property (@(posedge clk)
        !mr_n |-> q == '0); // R5

endmodule

// File: rtl/usr_bus_driver.sv
module usr_bus_driver
    import usr_pkg::*;
#(
    parameter int WIDTH = USR_WIDTH
) (
    input  logic             clk,
    input  logic             mr_n,
    input  usr_mode_e        mode,
    input  logic             en_a_n,
    input  logic             en_b_n,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] par_out,
    output logic             par_oe,
    output logic             tail_lo,
    output logic             tail_hi
);
    assign par_out = q;
    assign par_oe  = usr_may_drive(mode, en_a_n, en_b_n);
    assign tail_lo = q[0];
    assign tail_hi = q[WIDTH-1];

    AST_NO_DRIVE_ON_LOAD: assert property (@(posedge clk) disable iff (!mr_n)
        mode == MODE_LOAD |-> !par_oe); // R6

    AST_DRIVE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!mr_n)
        par_oe |-> (!en_a_n && !en_b_n)); // R6

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = USR_WIDTH
) (
    input  logic             clk,
    input  logic             mr_n,
    input  logic [1:0]       sel,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic             bus_en_a_n,
    input  logic             bus_en_b_n,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             par_oe,
    output logic             tail_lo,
    output logic             tail_hi
);
    usr_mode_e        mode;
    usr_serial_t      ser;
    logic [WIDTH-1:0] q;

    assign ser.up_in = ser_up_in;
    assign ser.dn_in = ser_dn_in;

    usr_mode_decode u_dec (
        .sel  (sel),
        .mode (mode)
    );

    usr_stage_array #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .mr_n   (mr_n),
        .mode   (mode),
        .ser    (ser),
        .par_in (par_in),
        .q      (q)
    );

    usr_bus_driver #(.WIDTH(WIDTH)) u_drv (
        .clk     (clk),
        .mr_n    (mr_n),
        .mode    (mode),
        .en_a_n  (bus_en_a_n),
        .en_b_n  (bus_en_b_n),
        .q       (q),
        .par_out (par_out),
        .par_oe  (par_oe),
        .tail_lo (tail_lo),
        .tail_hi (tail_hi)
    );
endmodule

// File: tb/test_usr_shift_reg.sv
module test_usr_shift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         mr_n = 1'b1;
    logic [1:0]   sel = 2'b00;
    logic         up_in = 1'b0;
    logic         dn_in = 1'b0;
    logic         en_a_n = 1'b1;
    logic         en_b_n = 1'b1;
    logic [W-1:0] pin = '0;
    logic [W-1:0] pout;
    logic         poe;
    logic         t_lo;
    logic         t_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) i_usr_shift_reg (
        .clk(clk), .mr_n(mr_n), .sel(sel), .ser_up_in(up_in), .ser_dn_in(dn_in),
        .bus_en_a_n(en_a_n), .bus_en_b_n(en_b_n), .par_in(pin),
        .par_out(pout), .par_oe(poe), .tail_lo(t_lo), .tail_hi(t_hi)
    );

    // sel, up_in, dn_in, en_a_n, en_b_n, par_in, expected contents, expected oe
    typedef struct packed {
        logic [1:0]   sel;
        logic         up;
        logic         dn;
        logic         ea;
        logic         eb;
        logic [W-1:0] din;
        logic [W-1:0] exp_q;
        logic         exp_oe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0}, // R1 load, R6 forced off
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B, 1'b1}, // R2
        '{2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h96, 1'b0}, // R2, R6
        '{2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hCB, 1'b0}, // R3, R6
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h65, 1'b1}, // R3
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h65, 1'b1}, // R4
        '{2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0}, // R1
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1E, 1'b1}  // R3
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1 mr_n = 1'b0;
        tick();
        tick();
        chk("R5 reset contents", pout, '0);
        chk("R8 reset tails", {6'd0, t_hi, t_lo}, '0);
        @(negedge clk) mr_n = 1'b1;

        // Vector walk: drive at the falling edge, judge just after the rising edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sel = VECS[i].sel; up_in = VECS[i].up; dn_in = VECS[i].dn;
            en_a_n = VECS[i].ea; en_b_n = VECS[i].eb; pin = VECS[i].din;
            tick();
            chk("R1-R4 vector contents (R7)", pout, VECS[i].exp_q);
            chk("R6 vector drive enable", {7'd0, poe}, {7'd0, VECS[i].exp_oe});
            chk("R8 tail_lo", {7'd0, t_lo}, {7'd0, VECS[i].exp_q[0]});
            chk("R8 tail_hi", {7'd0, t_hi}, {7'd0, VECS[i].exp_q[W-1]});
        end

        // R8: enables off must not affect the tails.
        @(negedge clk);
        sel = 2'b00; en_a_n = 1'b1; en_b_n = 1'b1;
        #1;
        chk("R8 tails with enables off", {6'd0, t_hi, t_lo}, 8'd0);
        chk("R6 off with enables high", {7'd0, poe}, 8'd0);

        // R6 collision: load selected with both enables low.
        @(negedge clk);
        sel = 2'b11; en_a_n = 1'b0; en_b_n = 1'b0; pin = 8'hC3;
        #1;
        chk("R6 load blocks drive", {7'd0, poe}, 8'd0);
        tick();
        chk("R1 load during enables", pout, 8'hC3);

        // R5: asynchronous clear between edges.
        @(negedge clk);
        sel = 2'b00;
        #2 mr_n = 1'b0;
        #1;
        chk("R5 async clear before edge", pout, 8'h00);

        // R5: clock edges with load selected during clear.
        sel = 2'b11; pin = 8'hFF;
        tick();
        tick();
        chk("R5 clear overrides load", pout, 8'h00);

        // R9: release between edges, first edge loads.
        @(negedge clk);
        pin = 8'h5A;
        mr_n = 1'b1;
        tick();
        chk("R9 first edge after release", pout, 8'h5A);

        // R4: keep mode ignores changing inputs over several edges.
        @(negedge clk);
        sel = 2'b00; pin = 8'h00; up_in = 1'b0; dn_in = 1'b1;
        tick();
        @(negedge clk) pin = 8'hFF; up_in = 1'b1; dn_in = 1'b0;
        tick();
        chk("R4 keep ignores inputs", pout, 8'h5A);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule